// File: doc/BRIEF.md
# SECAM Line-Alternation Detector

This block decides whether incoming colour is SECAM. A SECAM signal carries an identification burst whose frequency swaps between two values on alternate lines, while PAL and NTSC bursts keep one frequency. The block looks at the amplitude-limited chroma (a one-bit square wave) only while the burst-gate input is high. In that window it counts rising chroma edges against the system clock. It limits the count at a calibration value and stores it in one of two sample registers. A line-parity bit picks the register.

After each stored line, the absolute difference between the two registers feeds a leaky integrator. The integrator drives a detection flag with hysteresis. Because of the limit, a pair of lines that are both above the calibration frequency yields no difference. A three-level mode input then forces the chroma output on, gates it with the detection flag, or mutes it.

The control sequence runs through four states:

- IDLE clears the counter and waits for the burst gate.
- MEASURE counts edges until the gate falls.
- STORE writes the limited reading.
- INTEGRATE updates the integrator, but only when both registers hold a reading, and then returns to IDLE.

Top module: `secam_alt_detect`

## Requirements
- R1: A line's reading is the number of rising edges of `chroma_in` seen while `burst_gate` is high. The counter is cleared before each gate and saturates at its maximum.
- R2: A reading above `CLAMP_CNT` (default 26) is stored as `CLAMP_CNT`, so no sample register ever exceeds it.
- R3: The parity bit is cleared by `vsync` and toggles on each `hsync` without `vsync`; `vsync` wins when both occur. A reading goes into register 0 when parity is 0 and into register 1 otherwise.
- R4: After each stored reading, and only once both registers have held a reading since reset, the integrator updates once. The update is acc = acc - (acc >> `LEAK_SHIFT`) + |reg0 - reg1|, saturating at the accumulator maximum. With the defaults (`LEAK_SHIFT`=2), alternating readings 10 and 30 reach 28 after two updates.
- R5: `secam_det` sets when an update leaves acc above `TH_HI` (16). It clears when an update leaves acc below `TH_LO` (8). Between the two thresholds it holds.
- R6: A line with no burst-gate pulse leaves both registers, the integrator and `secam_det` unchanged.
- R7: `out_enable` is registered from `mode_sel`:
  - 2'b10: forced on (1).
  - 2'b00: forced mute (0).
  - 2'b01 or 2'b11: automatic; follows `secam_det`.
- R8: Reset (`rst_n` low) clears parity, both registers, their valid flags, the integrator, `secam_det` and `out_enable`.
- R9: A constant burst frequency on every line yields no difference and never sets `secam_det`.
- R10: Alternating readings that both lie above `CLAMP_CNT` yield no difference and never set `secam_det`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the counting reference |
| rst_n | input | 1 | Active-low synchronous reset |
| chroma_in | input | 1 | Amplitude-limited chroma square wave |
| hsync | input | 1 | One-cycle horizontal sync pulse |
| vsync | input | 1 | One-cycle vertical sync pulse |
| burst_gate | input | 1 | High during the line's identification window |
| mode_sel | input | 2 | Output mode: 10 forced on, 01/11 automatic, 00 mute |
| secam_det | output | 1 | SECAM detected flag |
| out_enable | output | 1 | Chroma output enable after the mode override |

## Verification
The assertions check the cycle-local rules on every cycle:

- The counter clears and holds as specified.
- The sample registers never exceed the limit and stay still without a store.
- Parity responds correctly to the two sync inputs.
- The detection flag only rises above the upper threshold and only falls below the lower one.
- The output enable obeys the mode input.

Only the bench scenarios can show the outcomes over many lines:

- Alternating bursts are detected after the expected number of lines, while constant, above-limit and too-short sequences are not.
- The flag releases only after the expected decay.
- Gate-less lines leave the integrator untouched.
- Repeated frame resets keep one register from ever pairing.

// File: rtl/secam_alt_pkg.sv
package secam_alt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MEASURE,
        ST_STORE,
        ST_INTEGRATE
    } det_state_t;

    typedef enum logic [1:0] {
        MODE_MUTE     = 2'b00,
        MODE_AUTO     = 2'b01,
        MODE_FORCE    = 2'b10,
        MODE_AUTO_ALT = 2'b11
    } mode_t;

endpackage

// File: rtl/burst_edge_counter.sv
module burst_edge_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chroma_in,
    input  logic             clear,
    input  logic             enable,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic prev_q;
    logic rise;

    assign rise = chroma_in & ~prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            count  <= '0;
        end else begin
            prev_q <= chroma_in;
            if (clear)
                count <= '0;
            else if (enable && rise && count != CNT_MAX)
                count <= count + 1'b1;
        end
    end

    // R1: a clear empties the counter on the next cycle
    p_clear_empties_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> count == '0);

    // R1: without enable or clear the count holds
    p_idle_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !enable) |=> $stable(count));

endmodule

// File: rtl/line_sample_pair.sv
module line_sample_pair #(
    parameter int CNT_W     = 8,
    parameter int CLAMP_CNT = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store,
    input  logic             parity,
    input  logic [CNT_W-1:0] reading,
    output logic [CNT_W-1:0] diff,
    output logic             both_valid
);
    localparam int               SLOTS   = 2;
    localparam logic [CNT_W-1:0] CLAMP_V = CNT_W'(CLAMP_CNT);

    logic [CNT_W-1:0] smp_q [SLOTS];
    logic [SLOTS-1:0] vld_q;
    logic [CNT_W-1:0] limited;

    assign limited = (reading > CLAMP_V) ? CLAMP_V : reading;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) smp_q[s] <= '0;
            vld_q <= '0;
        end else if (store) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (parity == 1'(s)) begin
                    smp_q[s] <= limited;
                    vld_q[s] <= 1'b1;
                end
            end
        end
    end

    assign diff       = (smp_q[0] >= smp_q[1]) ? (smp_q[0] - smp_q[1])
                                               : (smp_q[1] - smp_q[0]);
    assign both_valid = &vld_q;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot_chk
        // R2: no stored sample exceeds the calibration limit
        p_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
            smp_q[s] <= CLAMP_V);

        // R6: a slot changes only on a store
        p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !store |=> $stable(smp_q[s]));
    end

endmodule

// File: rtl/leaky_hyst_detector.sv
module leaky_hyst_detector #(
    parameter int CNT_W      = 8,
    parameter int ACC_W      = 12,
    parameter int LEAK_SHIFT = 2,
    parameter int TH_HI      = 16,
    parameter int TH_LO      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             update,
    input  logic [CNT_W-1:0] diff,
    output logic             det
);
    localparam logic [ACC_W-1:0] TH_HI_V = ACC_W'(TH_HI);
    localparam logic [ACC_W-1:0] TH_LO_V = ACC_W'(TH_LO);
    localparam int               PAD_W   = ACC_W + 1 - CNT_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;
    logic [ACC_W-1:0] acc_next;

    always_comb begin
        sum      = {1'b0, acc_q} - ({1'b0, acc_q} >> LEAK_SHIFT)
                 + {{PAD_W{1'b0}}, diff};
        acc_next = sum[ACC_W] ? '1 : sum[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            det   <= 1'b0;
        end else if (update) begin
            acc_q <= acc_next;
            if (acc_next > TH_HI_V)
                det <= 1'b1;
            else if (acc_next < TH_LO_V)
                det <= 1'b0;
        end
    end

    // R5: detection only sets with the integrator above the upper threshold
    p_set_above_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det) |-> acc_q > TH_HI_V);

    // R5: detection only clears with the integrator below the lower threshold
    p_clear_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(det) |-> acc_q < TH_LO_V);

    // R4: the integrator moves only on an update
    p_acc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !update |=> $stable(acc_q));

endmodule

// File: rtl/secam_alt_detect.sv
module secam_alt_detect
    import secam_alt_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int CLAMP_CNT  = 26,
    parameter int ACC_W      = 12,
    parameter int LEAK_SHIFT = 2,
    parameter int TH_HI      = 16,
    parameter int TH_LO      = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chroma_in,
    input  logic       hsync,
    input  logic       vsync,
    input  logic       burst_gate,
    input  logic [1:0] mode_sel,
    output logic       secam_det,
    output logic       out_enable
);
    det_state_t       state_q, state_d;
    logic             cnt_clear, cnt_en, store_en, integ_en;
    logic             parity_q;
    logic             both_valid;
    logic             out_en_d;
    logic [CNT_W-1:0] reading;
    logic [CNT_W-1:0] diff;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and control outputs
    always_comb begin
        state_d   = state_q;
        cnt_clear = 1'b0;
        cnt_en    = 1'b0;
        store_en  = 1'b0;
        integ_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_clear = 1'b1;
                if (burst_gate) state_d = ST_MEASURE;
            end
            ST_MEASURE: begin
                cnt_en = 1'b1;
                if (!burst_gate) state_d = ST_STORE;
            end
            ST_STORE: begin
                store_en = 1'b1;
                state_d  = ST_INTEGRATE;
            end
            ST_INTEGRATE: begin
                integ_en = both_valid;
                state_d  = ST_IDLE;
            end
        endcase
    end

    // line parity
    always_ff @(posedge clk) begin
        if (!rst_n)     parity_q <= 1'b0;
        else if (vsync) parity_q <= 1'b0;
        else if (hsync) parity_q <= ~parity_q;
    end

    burst_edge_counter #(.CNT_W(CNT_W)) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .chroma_in (chroma_in),
        .clear     (cnt_clear),
        .enable    (cnt_en),
        .count     (reading)
    );

    line_sample_pair #(.CNT_W(CNT_W), .CLAMP_CNT(CLAMP_CNT)) i_samples (
        .clk        (clk),
        .rst_n      (rst_n),
        .store      (store_en),
        .parity     (parity_q),
        .reading    (reading),
        .diff       (diff),
        .both_valid (both_valid)
    );

    leaky_hyst_detector #(
        .CNT_W(CNT_W), .ACC_W(ACC_W), .LEAK_SHIFT(LEAK_SHIFT),
        .TH_HI(TH_HI), .TH_LO(TH_LO)
    ) i_detector (
        .clk    (clk),
        .rst_n  (rst_n),
        .update (integ_en),
        .diff   (diff),
        .det    (secam_det)
    );

    // mode override
    always_comb begin
        unique case (mode_t'(mode_sel))
            MODE_FORCE:    out_en_d = 1'b1;
            MODE_MUTE:     out_en_d = 1'b0;
            MODE_AUTO,
            MODE_AUTO_ALT: out_en_d = secam_det;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_enable <= 1'b0;
        else        out_enable <= out_en_d;
    end

    // R3: vertical sync returns parity to zero
    p_vsync_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> !parity_q);

    // R3: a lone horizontal sync flips parity
    p_hsync_flips_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync && !vsync) |=> parity_q != $past(parity_q));

    // R7: forced mute keeps the output disabled
    p_mute_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00) |=> !out_enable);

    // R7: forced SECAM keeps the output enabled
    p_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b10) |=> out_enable);

    // R7: automatic mode follows the detection flag
    p_auto_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel[0] == 1'b1) |=> out_enable == $past(secam_det));

endmodule

// File: tb/test_secam_alt_detect.sv
module test_secam_alt_detect;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chroma_in = 1'b0;
    logic       hsync = 1'b0;
    logic       vsync = 1'b0;
    logic       burst_gate = 1'b0;
    logic [1:0] mode_sel = 2'b01;
    logic       secam_det;
    logic       out_enable;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    secam_alt_detect i_secam_alt_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .chroma_in  (chroma_in),
        .hsync      (hsync),
        .vsync      (vsync),
        .burst_gate (burst_gate),
        .mode_sel   (mode_sel),
        .secam_det  (secam_det),
        .out_enable (out_enable)
    );

    // vector table: even-line count, odd-line count, lines, expected detection
    localparam int    NV = 5;
    localparam int    V_EVEN  [NV] = '{20, 28, 30, 20, 10};
    localparam int    V_ODD   [NV] = '{30, 28, 32, 30, 30};
    localparam int    V_LINES [NV] = '{ 8,  8,  8,  3,  3};
    localparam bit    V_DET   [NV] = '{ 1,  0,  0,  0,  1};
    localparam string V_REQ   [NV] = '{"R1", "R9", "R10", "R2", "R4"};

    task automatic check(input bit got, input bit exp, input string req,
                         input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic do_vsync();
        vsync = 1'b1;
        tick(1);
        vsync = 1'b0;
        tick(2);
    endtask

    task automatic do_line(input int pulses, input bit gate);
        hsync = 1'b1;
        tick(1);
        hsync = 1'b0;
        tick(3);
        if (gate) begin
            burst_gate = 1'b1;
            tick(2);
            for (int p = 0; p < pulses; p++) begin
                chroma_in = 1'b1;
                tick(2);
                chroma_in = 1'b0;
                tick(2);
            end
            tick(2);
            burst_gate = 1'b0;
        end
        tick(8);
    endtask

    task automatic run_pair(input int ev, input int od, input int lines);
        for (int l = 0; l < lines; l++)
            do_line((l % 2 == 0) ? ev : od, 1'b1);
    endtask

    initial begin
        #1000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
        $finish;
    end

    initial begin
        // R8: reset state
        mode_sel = 2'b01;
        do_reset();
        check(secam_det, 1'b0, "R8", "secam_det after reset");
        check(out_enable, 1'b0, "R8", "out_enable after reset");

        // table walk
        for (int v = 0; v < NV; v++) begin
            do_reset();
            do_vsync();
            run_pair(V_EVEN[v], V_ODD[v], V_LINES[v]);
            tick(2);
            check(secam_det, V_DET[v], V_REQ[v], "secam_det for vector");
            check(out_enable, V_DET[v], "R7", "auto out_enable for vector");
        end

        // R5 and R6: hysteresis decay, gate-less lines in the middle
        do_reset();
        do_vsync();
        run_pair(20, 30, 8);
        run_pair(30, 30, 4);
        check(secam_det, 1'b1, "R5", "held between thresholds");
        for (int g = 0; g < 3; g++) do_line(30, 1'b0);
        check(secam_det, 1'b1, "R6", "gate-less lines leave state");
        do_line(30, 1'b1);
        check(secam_det, 1'b0, "R5", "released below lower threshold");

        // R7: mode override with detection low
        mode_sel = 2'b10; tick(2);
        check(out_enable, 1'b1, "R7", "forced on, det low");
        mode_sel = 2'b00; tick(2);
        check(out_enable, 1'b0, "R7", "mute, det low");
        mode_sel = 2'b01; tick(2);
        check(out_enable, 1'b0, "R7", "auto, det low");

        // R7: mode override with detection high
        do_reset();
        do_vsync();
        run_pair(10, 30, 3);
        check(secam_det, 1'b1, "R4", "detect after two updates");
        mode_sel = 2'b00; tick(2);
        check(out_enable, 1'b0, "R7", "mute, det high");
        mode_sel = 2'b10; tick(2);
        check(out_enable, 1'b1, "R7", "forced on, det high");
        mode_sel = 2'b11; tick(2);
        check(out_enable, 1'b1, "R7", "auto alt code, det high");
        mode_sel = 2'b01; tick(2);
        check(out_enable, 1'b1, "R7", "auto, det high");

        // R3: frame reset before every line keeps writing one register
        do_reset();
        for (int l = 0; l < 6; l++) begin
            do_vsync();
            do_line((l % 2 == 0) ? 10 : 30, 1'b1);
        end
        check(secam_det, 1'b0, "R3", "vsync realigns parity each line");

        $display("  End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
        $finish;
    end

endmodule